// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block handles hardware handshaking for one serial channel. On the receive side it watches the fill count of the receive FIFO and drives the active-low request-to-send line. The threshold that releases RTS is separate from the threshold that asserts it again. Both come from the trigger levels next to the one software selected. This gives hysteresis, so the far end is not switched on and off on every character. The receiver itself is never stalled by this block: characters keep landing in the FIFO until it is full.

On the transmit side it watches the active-low clear-to-send pin through a synchronizer. It tells the transmitter, through `tx_start_allow`, whether a new character may begin. The transmitter samples that flag only at a character boundary, so a character already on the line always finishes. When automatic RTS is off, the RTS pin follows a software modem-control bit. When automatic CTS is off, the CTS pin is ignored.

Top module: `autoflow_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `rts_n` is 1 and `tx_start_allow` is 0.
- R2: With `auto_rts_en`=1, a `rx_count` at or above the upper level drives `rts_n` to 1 one cycle later. The upper level for `trig_sel` 0,1,2,3 is 4, 8, 14 and 16 (the FIFO depth).
- R3: With `auto_rts_en`=1, a `rx_count` at or below the lower level drives `rts_n` to 0 one cycle later. The lower level for `trig_sel` 0,1,2,3 is 0, 1, 4 and 8.
- R4: With `auto_rts_en`=1, a count strictly between the two levels, including the selected trigger level itself (1, 4, 8, 14), leaves `rts_n` unchanged.
- R5: With `auto_rts_en`=0, `rts_n` equals the inverse of `sw_rts` one cycle later, whatever the count is.
- R6: With `auto_cts_en`=0, `tx_start_allow` equals `tx_idle` one cycle later, and `cts_n` has no effect.
- R7: With `auto_cts_en`=1 and `tx_idle`=1, `tx_start_allow` is 1 only when `cts_n` is low. A change on `cts_n` reaches `tx_start_allow` three cycles later (two synchronizer stages plus the output register).
- R8: With `tx_idle`=0 (a character in progress), `tx_start_allow` is 0 one cycle later, whatever CTS is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_count | input | 5 | Receive FIFO fill count, 0..DEPTH |
| trig_sel | input | 2 | Receive trigger level select (0..3 for 1, 4, 8, 14 bytes) |
| auto_rts_en | input | 1 | Enables automatic RTS from the FIFO level |
| auto_cts_en | input | 1 | Enables CTS gating of new characters (0 after reset in software) |
| sw_rts | input | 1 | Software RTS bit; 1 drives `rts_n` low when automatic RTS is off |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_idle | input | 1 | Transmitter is at a character boundary and free to start |
| rts_n | output | 1 | Request-to-send pin, active low, registered |
| tx_start_allow | output | 1 | A new character may start, registered |

## Verification
The bench walks the FIFO count up and down through every trigger setting. It checks that RTS rises only at the level above the selected one, and is not released early when the count sits at the selected level. A design that used one threshold would toggle on the programmed level, and one with swapped levels would release RTS too late or too early. It also checks the low end with select 0, where RTS must wait for an empty FIFO, and the top end with select 3, where only a full FIFO drops it. On the transmit side it measures the exact three-cycle latency from CTS to the start flag, checks that a busy transmitter is never given a start, and checks that CTS is ignored when gating is disabled.

// File: rtl/autoflow_pkg.sv
package autoflow_pkg;
  typedef enum logic [1:0] {
    TRIG_A = 2'd0,
    TRIG_B = 2'd1,
    TRIG_C = 2'd2,
    TRIG_D = 2'd3
  } trig_sel_e;

  localparam int NUM_TRIG = 4;
endpackage

// File: rtl/autoflow_level_dec.sv
module autoflow_level_dec
  import autoflow_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] hi_lvl,
  output logic [CNT_W-1:0] lo_lvl
);
  localparam int NLV = NUM_TRIG + 2;

  // ladder: 0, four trigger levels, full depth
  logic [CNT_W-1:0] ladder [NLV];

  for (genvar g = 0; g < NLV; g++) begin : g_ladder
    localparam int V = (g == 0) ? 0 :
                       (g == 1) ? LVL0 :
                       (g == 2) ? LVL1 :
                       (g == 3) ? LVL2 :
                       (g == 4) ? LVL3 : DEPTH;
    assign ladder[g] = CNT_W'(V);
  end

  always_comb begin
    hi_lvl = ladder[NLV-1];
    lo_lvl = ladder[0];
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (sel == 2'(i)) begin
        hi_lvl = ladder[i + 2];
        lo_lvl = ladder[i];
      end
    end
  end
endmodule

// File: rtl/autoflow_rts.sv
module autoflow_rts #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_en,
  input  logic             sw_rts,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] hi_lvl,
  input  logic [CNT_W-1:0] lo_lvl,
  output logic             rts_n
);
  logic rts_n_q;
  logic rts_n_d;

  always_comb begin
    rts_n_d = rts_n_q;
    if (!auto_en)               rts_n_d = ~sw_rts;
    else if (count >= hi_lvl)   rts_n_d = 1'b1;
    else if (count <= lo_lvl)   rts_n_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rts_n_q <= 1'b1;
    else     rts_n_q <= rts_n_d;
  end

  assign rts_n = rts_n_q;

  // R2
  rts_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_en && count >= hi_lvl) |=> rts_n);

  // R3
  rts_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_en && count <= lo_lvl) |=> !rts_n);

  // R4
  rts_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_en && count > lo_lvl && count < hi_lvl) |=> $stable(rts_n));

  // R5
  rts_sw_chk: assert property (@(posedge clk) disable iff (rst)
    (!auto_en) |=> (rts_n == !$past(sw_rts)));
endmodule

// File: rtl/autoflow_sync.sv
module autoflow_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= RST_VAL;
      else     chain[g] <= (g == 0) ? din : chain[(g == 0) ? 0 : g - 1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/autoflow_cts.sv
module autoflow_cts (
  input  logic clk,
  input  logic rst,
  input  logic auto_en,
  input  logic cts_n_s,
  input  logic tx_idle,
  output logic start_ok
);
  logic ok_q;

  always_ff @(posedge clk) begin
    if (rst) ok_q <= 1'b0;
    else     ok_q <= tx_idle & (~auto_en | ~cts_n_s);
  end

  assign start_ok = ok_q;

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_idle) |=> !start_ok);

  // R6
  cts_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!auto_en) |=> (start_ok == $past(tx_idle)));

  // R7
  cts_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_en && cts_n_s) |=> !start_ok);

  // R7
  cts_go_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_en && !cts_n_s && tx_idle) |=> start_ok);
endmodule

// File: rtl/autoflow_ctrl.sv
module autoflow_ctrl #(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int LVL0        = 1,
  parameter int LVL1        = 4,
  parameter int LVL2        = 8,
  parameter int LVL3        = 14,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [1:0]       trig_sel,
  input  logic             auto_rts_en,
  input  logic             auto_cts_en,
  input  logic             sw_rts,
  input  logic             cts_n,
  input  logic             tx_idle,
  output logic             rts_n,
  output logic             tx_start_allow
);
  logic [CNT_W-1:0] hi_lvl;
  logic [CNT_W-1:0] lo_lvl;
  logic             cts_n_s;

  autoflow_level_dec #(
    .DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
  ) u_dec (
    .sel   (trig_sel),
    .hi_lvl(hi_lvl),
    .lo_lvl(lo_lvl)
  );

  autoflow_rts #(.DEPTH(DEPTH)) u_rts (
    .clk    (clk),
    .rst    (rst),
    .auto_en(auto_rts_en),
    .sw_rts (sw_rts),
    .count  (rx_count),
    .hi_lvl (hi_lvl),
    .lo_lvl (lo_lvl),
    .rts_n  (rts_n)
  );

  autoflow_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (cts_n),
    .dout(cts_n_s)
  );

  autoflow_cts u_cts (
    .clk     (clk),
    .rst     (rst),
    .auto_en (auto_cts_en),
    .cts_n_s (cts_n_s),
    .tx_idle (tx_idle),
    .start_ok(tx_start_allow)
  );
endmodule

// File: tb/autoflow_ctrl_tb_top.sv
`timescale 1ns/1ps
module autoflow_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] rx_count;
  logic [1:0] trig_sel;
  logic       auto_rts_en, auto_cts_en, sw_rts, cts_n, tx_idle;
  logic       rts_n, tx_start_allow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  autoflow_ctrl dut_i (
    .clk(clk), .rst(rst), .rx_count(rx_count), .trig_sel(trig_sel),
    .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en), .sw_rts(sw_rts),
    .cts_n(cts_n), .tx_idle(tx_idle), .rts_n(rts_n),
    .tx_start_allow(tx_start_allow)
  );

  // entry: [9:8] sel, [7] auto_rts, [6] sw_rts, [5:1] count, [0] expected rts_n
  localparam int NV = 24;
  localparam logic [9:0] VEC [NV] = '{
    {2'd1, 1'b1, 1'b0, 5'd0,  1'b0},  // R3 drained
    {2'd1, 1'b1, 1'b0, 5'd4,  1'b0},  // R4 at trigger
    {2'd1, 1'b1, 1'b0, 5'd7,  1'b0},  // R4
    {2'd1, 1'b1, 1'b0, 5'd8,  1'b1},  // R2 upper
    {2'd1, 1'b1, 1'b0, 5'd4,  1'b1},  // R4
    {2'd1, 1'b1, 1'b0, 5'd2,  1'b1},  // R4
    {2'd1, 1'b1, 1'b0, 5'd1,  1'b0},  // R3 lower
    {2'd1, 1'b1, 1'b0, 5'd5,  1'b0},  // R4
    {2'd0, 1'b1, 1'b0, 5'd3,  1'b0},  // R4
    {2'd0, 1'b1, 1'b0, 5'd4,  1'b1},  // R2
    {2'd0, 1'b1, 1'b0, 5'd1,  1'b1},  // R4 at trigger 1
    {2'd0, 1'b1, 1'b0, 5'd0,  1'b0},  // R3 empty
    {2'd3, 1'b1, 1'b0, 5'd14, 1'b0},  // R4
    {2'd3, 1'b1, 1'b0, 5'd15, 1'b0},  // R4
    {2'd3, 1'b1, 1'b0, 5'd16, 1'b1},  // R2 full
    {2'd3, 1'b1, 1'b0, 5'd9,  1'b1},  // R4
    {2'd3, 1'b1, 1'b0, 5'd8,  1'b0},  // R3
    {2'd2, 1'b1, 1'b0, 5'd13, 1'b0},  // R4
    {2'd2, 1'b1, 1'b0, 5'd14, 1'b1},  // R2
    {2'd2, 1'b1, 1'b0, 5'd5,  1'b1},  // R4
    {2'd2, 1'b1, 1'b0, 5'd4,  1'b0},  // R3
    {2'd2, 1'b0, 1'b1, 5'd16, 1'b0},  // R5
    {2'd2, 1'b0, 1'b0, 5'd0,  1'b1},  // R5
    {2'd2, 1'b0, 1'b1, 5'd0,  1'b0}   // R5
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rx_count = '0; trig_sel = 2'd0; auto_rts_en = 1'b0;
    auto_cts_en = 1'b0; sw_rts = 1'b1; cts_n = 1'b0; tx_idle = 1'b1;
    @(negedge clk);
    tick();
    check("R1 rts_n in reset", rts_n, 1'b1);
    check("R1 allow in reset", tx_start_allow, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      trig_sel    = VEC[i][9:8];
      auto_rts_en = VEC[i][7];
      sw_rts      = VEC[i][6];
      rx_count    = VEC[i][5:1];
      tick();
      check($sformatf("R2-4/R5 vec %0d", i), rts_n, VEC[i][0]);
    end

    // R6: gating off, CTS high ignored
    auto_cts_en = 1'b0; cts_n = 1'b1; tx_idle = 1'b1;
    tick();
    check("R6 cts ignored", tx_start_allow, 1'b1);
    // R8: busy transmitter
    tx_idle = 1'b0;
    tick();
    check("R8 busy", tx_start_allow, 1'b0);
    // R7: gating on, CTS inactive
    tx_idle = 1'b1; auto_cts_en = 1'b1;
    repeat (4) tick();
    check("R7 cts inactive", tx_start_allow, 1'b0);
    cts_n = 1'b0;
    tick(); tick();
    check("R7 latency 2", tx_start_allow, 1'b0);
    tick();
    check("R7 latency 3", tx_start_allow, 1'b1);
    tx_idle = 1'b0;
    tick();
    check("R8 busy cts ok", tx_start_allow, 1'b0);
    tx_idle = 1'b1;
    tick();
    cts_n = 1'b1;
    tick(); tick();
    check("R7 drop latency 2", tx_start_allow, 1'b1);
    tick();
    check("R7 drop latency 3", tx_start_allow, 1'b0);

    // R1: mid-run reset with software RTS asserted
    auto_rts_en = 1'b0; sw_rts = 1'b1; cts_n = 1'b0;
    tick();
    check("R5 pre-reset", rts_n, 1'b0);
    rst = 1'b1;
    tick();
    check("R1 rts_n after reset", rts_n, 1'b1);
    check("R1 allow after reset", tx_start_allow, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule